// File: doc/BRIEF.md
# Supply Latchup Guard Controller

This block decides whether an over-current reported by the supply monitors is a latchup or only a short glitch, and it sequences the power cycle that clears a real latchup. It has two comparator flags as inputs, one for the analog rail and one for the digital rail, plus a self-test input that behaves as an over-current on both rails. All three inputs are asynchronous, so each passes through a two-flop synchroniser before use. When any of them goes high, a decision window of `DECIDE_CYC` clocks opens and the status output rises.

If the over-current is still present when the window closes, both rail switches open. The input isolation gates turn off and the crowbar on the protected I/O is enabled. This state lasts `OFF_CYC` clocks, after which power returns. Three recovery flags then rise in order: functional, coarse accuracy and full accuracy. A saturating counter records each completed power cycle.

The status and control pins are plain level signals. There is no data stream, so there is no handshake. Every interval is a parameter expressed in clock cycles.

Top module: `supply_guard`

## Requirements
- R1: After reset, the block is in this state: status low, both rail enables high, isolation gates on, crowbar off, all three recovery flags high, trip count zero.
- R2: An over-current input (analog flag, digital flag or self-test) that is first high before clock edge k raises the status output at edge k+2. The status output is therefore seen high after the third edge counted from the input change.
- R3: The status output stays high for exactly `DECIDE_CYC` cycles after it rises. If the synchronised over-current falls within the window, status then falls, the rail enables never drop and the trip count does not change.
- R4: If the synchronised over-current stays high through the whole window, both rail enables fall exactly `DECIDE_CYC` cycles after status rose. They stay low for exactly `OFF_CYC` cycles. During that time the status output is high, the isolation gates are off and the crowbar is on.
- R5: In the cycle where the rail enables return high, the status output falls, the isolation gates turn back on and the crowbar turns off.
- R6: Over-current inputs that are high only during the power-off interval, and low again at least two cycles before it ends, do not start a new decision window.
- R7: All three recovery flags fall when the rails switch off. Counted from the cycle in which the rails return, the functional flag rises after exactly `FUNC_CYC` cycles, the coarse flag after `COARSE_CYC` cycles and the full flag after `FULL_CYC` cycles.
- R8: The self-test input acts as an over-current on both rails. A pulse longer than the window produces exactly one power cycle. Holding it high makes the block cycle power again and again, and status is low for exactly one cycle between the end of one power-off interval and the start of the next window.
- R9: The trip count increases by one in the cycle the rails return. It stops at 2^`CNT_W`-1 and does not wrap.
- R10: A new trip that happens before the recovery flags have risen clears them again and restarts all recovery timing from the new restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_ana_i | input | 1 | Analog rail over-current flag, asynchronous |
| oc_dig_i | input | 1 | Digital rail over-current flag, asynchronous |
| bist_i | input | 1 | Self-test input that emulates an over-current on both rails |
| ana_pwr_en_o | output | 1 | Analog rail switch enable, high = powered |
| dig_pwr_en_o | output | 1 | Digital rail switch enable, high = powered |
| iso_on_o | output | 1 | Input isolation gates conducting |
| crowbar_o | output | 1 | Protected I/O clamp enable |
| lp_status_o | output | 1 | High from window start until power returns or the window ends |
| func_ok_o | output | 1 | Functional recovery reached |
| coarse_ok_o | output | 1 | Coarse accuracy recovery reached |
| full_ok_o | output | 1 | Full accuracy recovery reached |
| trip_count_o | output | CNT_W | Saturating count of completed power cycles |

## Verification
A controller whose window counter or hold tracking is corrupted shows this at the ports on the first event. Status then falls, or the rail enables drop, one or more cycles away from the expected `DECIDE_CYC`, or the enables drop after a glitch that went away. A fault in the off-interval timer makes the enables return early or late. A fault in the recovery timer moves the rising edge of a recovery flag by at least one cycle within `FULL_CYC` of the restore. Faults in the trip counter appear at the next restore as a missing step or as a wrap past the maximum.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECIDE = 2'd1,
    ST_OFF    = 2'd2
  } guard_st_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/sg_fsm.sv
module sg_fsm
  import sg_pkg::*;
#(
  parameter int unsigned DECIDE_CYC = 1000,
  parameter int unsigned OFF_CYC    = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc,
  output logic pwr_on,
  output logic status,
  output logic trip,
  output logic restore
);
  localparam int unsigned CW = $clog2(max2(DECIDE_CYC, OFF_CYC) + 1);
  localparam logic [CW-1:0] D_LAST = CW'(DECIDE_CYC - 1);
  localparam logic [CW-1:0] O_LAST = CW'(OFF_CYC - 1);

  guard_st_e     state;
  logic [CW-1:0] cnt;
  logic          held;

  assign trip    = (state == ST_DECIDE) && (cnt == D_LAST) && held && oc;
  assign restore = (state == ST_OFF) && (cnt == O_LAST);
  assign pwr_on  = (state != ST_OFF);
  assign status  = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      held  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (oc) begin
            state <= ST_DECIDE;
            cnt   <= '0;
            held  <= 1'b1;
          end
        end
        ST_DECIDE: begin
          held <= held & oc;
          if (cnt == D_LAST) begin
            cnt   <= '0;
            state <= trip ? ST_OFF : ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_OFF: begin
          if (restore) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: the off state is only ever entered from a completed decision window
  a_r4_off_from_decide: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF && $past(state) != ST_OFF) |-> ($past(state) == ST_DECIDE));

  // R6: flags cannot shorten the off interval
  a_r6_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF && cnt != O_LAST) |=> (state == ST_OFF));
endmodule

// File: rtl/sg_recovery.sv
module sg_recovery #(
  parameter int unsigned FUNC_CYC   = 2500,
  parameter int unsigned COARSE_CYC = 3000,
  parameter int unsigned FULL_CYC   = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip,
  input  logic       restore,
  output logic [2:0] ready
);
  localparam int unsigned RW = $clog2(FULL_CYC + 1);
  localparam int unsigned TH [3] = '{FUNC_CYC, COARSE_CYC, FULL_CYC};
  localparam logic [RW-1:0] R_LAST = RW'(FULL_CYC - 1);

  logic          run;
  logic [RW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (trip) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (restore) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
      if (cnt == R_LAST) run <= 1'b0;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_stage
    localparam logic [RW-1:0] HIT = RW'(TH[i] - 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     ready[i] <= 1'b1;
      else if (trip)                  ready[i] <= 1'b0;
      else if (run && cnt == HIT)     ready[i] <= 1'b1;
    end
  end

  // R7: full accuracy implies the earlier stages
  a_r7_stage_order: assert property (@(posedge clk) disable iff (!rst_n)
    ready[2] |-> (ready[1] && ready[0]));
endmodule

// File: rtl/sg_trip_counter.sv
module sg_trip_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  // R9: never wraps
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == TOP) |-> (count == TOP));
  // R9: changes only after a restore pulse
  a_r9_step_on_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> $past(inc));
endmodule

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int unsigned DECIDE_CYC = 1000,
  parameter int unsigned OFF_CYC    = 5000,
  parameter int unsigned FUNC_CYC   = 2500,
  parameter int unsigned COARSE_CYC = 3000,
  parameter int unsigned FULL_CYC   = 500000,
  parameter int unsigned CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oc_ana_i,
  input  logic             oc_dig_i,
  input  logic             bist_i,
  output logic             ana_pwr_en_o,
  output logic             dig_pwr_en_o,
  output logic             iso_on_o,
  output logic             crowbar_o,
  output logic             lp_status_o,
  output logic             func_ok_o,
  output logic             coarse_ok_o,
  output logic             full_ok_o,
  output logic [CNT_W-1:0] trip_count_o
);
  logic [2:0] raw_in, synced;
  logic       oc_any, pwr_on, trip, restore;
  logic [2:0] ready;

  assign raw_in = {bist_i, oc_dig_i, oc_ana_i};

  sg_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(synced)
  );

  assign oc_any = |synced;

  sg_fsm #(.DECIDE_CYC(DECIDE_CYC), .OFF_CYC(OFF_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .oc(oc_any),
    .pwr_on(pwr_on), .status(lp_status_o), .trip(trip), .restore(restore)
  );

  sg_recovery #(.FUNC_CYC(FUNC_CYC), .COARSE_CYC(COARSE_CYC), .FULL_CYC(FULL_CYC)) u_rec (
    .clk(clk), .rst_n(rst_n), .trip(trip), .restore(restore), .ready(ready)
  );

  sg_trip_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(restore), .count(trip_count_o)
  );

  assign ana_pwr_en_o = pwr_on;
  assign dig_pwr_en_o = pwr_on;
  assign iso_on_o     = pwr_on;
  assign crowbar_o    = ~pwr_on;
  assign func_ok_o    = ready[0];
  assign coarse_ok_o  = ready[1];
  assign full_ok_o    = ready[2];

  // R7: no recovery stage is reported while the rails are off
  a_r7_dark_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (ready == 3'b000));
  // R4: status is high whenever power is removed
  a_r4_status_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> lp_status_o);
endmodule

// File: tb/supply_guard_tb.sv
module supply_guard_tb;
  localparam int D  = 16;
  localparam int OF = 40;
  localparam int FU = 20;
  localparam int CO = 50;
  localparam int FL = 120;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc_ana = 1'b0, oc_dig = 1'b0, bist = 1'b0;
  logic ana_en, dig_en, iso_on, crowbar, status, func_ok, coarse_ok, full_ok;
  logic [CW-1:0] tcount;
  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  supply_guard #(.DECIDE_CYC(D), .OFF_CYC(OF), .FUNC_CYC(FU), .COARSE_CYC(CO),
                 .FULL_CYC(FL), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .oc_ana_i(oc_ana), .oc_dig_i(oc_dig), .bist_i(bist),
    .ana_pwr_en_o(ana_en), .dig_pwr_en_o(dig_en), .iso_on_o(iso_on),
    .crowbar_o(crowbar), .lp_status_o(status), .func_ok_o(func_ok),
    .coarse_ok_o(coarse_ok), .full_ok_o(full_ok), .trip_count_o(tcount)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!status && n < 200) begin tick(); n++; end
  endtask

  // Trip through one power cycle; inject an over-current inside the off interval if asked
  task automatic do_trip(input int src, input bit inject, input int exp_cnt);
    int n, k;
    bit st_ok;
    if (src == 0) oc_ana = 1'b1; else oc_dig = 1'b1;
    wait_rise(n);
    check(n == 3, "R2 status rise delay", n, 3);
    k = 0;
    while (ana_en && k < 500) begin tick(); k++; end
    check(k == D, "R4 window length before power off", k, D);
    check(!dig_en && !iso_on && crowbar && status, "R4 off-state outputs", {dig_en, iso_on, crowbar, status}, 4'b0011);
    check({func_ok, coarse_ok, full_ok} == 3'b000, "R7 flags cleared at trip", {func_ok, coarse_ok, full_ok}, 0);
    oc_ana = 1'b0; oc_dig = 1'b0;
    k = 0; st_ok = 1'b1;
    while (!ana_en && k < 500) begin
      if (!status) st_ok = 1'b0;
      if (inject && k == 5)  oc_ana = 1'b1;
      if (inject && k == 10) oc_ana = 1'b0;
      tick(); k++;
    end
    check(k == OF, "R4 off interval length", k, OF);
    check(st_ok, "R4 status high while off", st_ok, 1);
    check(!status && iso_on && !crowbar && dig_en, "R5 restore outputs", {status, iso_on, crowbar, dig_en}, 4'b0101);
    check(int'(tcount) == exp_cnt, "R9 trip count step", tcount, exp_cnt);
  endtask

  task automatic measure_recovery(input string tag);
    int f, c, u;
    bit quiet;
    f = -1; c = -1; u = -1; quiet = 1'b1;
    for (int t = 1; t <= FL + 5; t++) begin
      tick();
      if (status) quiet = 1'b0;
      if (func_ok && f < 0)   f = t;
      if (coarse_ok && c < 0) c = t;
      if (full_ok && u < 0)   u = t;
    end
    check(f == FU, {tag, " functional flag delay"}, f, FU);
    check(c == CO, {tag, " coarse flag delay"}, c, CO);
    check(u == FL, {tag, " full flag delay"}, u, FL);
    check(quiet, {tag, " no new window"}, quiet, 1);
  endtask

  task automatic t_reset();
    check(!status && ana_en && dig_en && iso_on && !crowbar, "R1 reset control outputs",
          {status, ana_en, dig_en, iso_on, crowbar}, 5'b01110);
    check({func_ok, coarse_ok, full_ok} == 3'b111 && tcount == 0, "R1 reset flags and count",
          {func_ok, coarse_ok, full_ok, tcount}, 6'b111000);
  endtask

  task automatic t_transient();
    int n, k;
    bit pwr_ok;
    oc_ana = 1'b1;
    wait_rise(n);
    check(n == 3, "R2 status rise delay", n, 3);
    k = 0; pwr_ok = 1'b1;
    while (status && k < 500) begin
      if (k == 3) oc_ana = 1'b0;
      if (!ana_en || !dig_en) pwr_ok = 1'b0;
      tick(); k++;
    end
    check(k == D, "R3 aborted window length", k, D);
    check(pwr_ok && ana_en, "R3 power untouched", pwr_ok, 1);
    check(tcount == 0 && func_ok, "R3 count and flags unchanged", tcount, 0);
  endtask

  task automatic t_trip_dig();
    do_trip(1, 1'b0, 1);
    measure_recovery("R7");
  endtask

  task automatic t_ignore_off();
    bit quiet;
    do_trip(0, 1'b1, 2);
    quiet = 1'b1;
    for (int i = 0; i < 30; i++) begin tick(); if (status) quiet = 1'b0; end
    check(quiet, "R6 off-interval flag ignored", quiet, 1);
    check(tcount == 2, "R6 single power cycle", tcount, 2);
  endtask

  task automatic t_bist_pulse();
    int k;
    bit quiet;
    bist = 1'b1;
    repeat (D + 4) tick();
    bist = 1'b0;
    k = 0;
    while (ana_en && k < 500) begin tick(); k++; end
    while (!ana_en && k < 500) begin tick(); k++; end
    check(tcount == 3, "R8 test pulse gives one cycle", tcount, 3);
    quiet = 1'b1;
    for (int i = 0; i < D + 20; i++) begin tick(); if (!ana_en || status) quiet = 1'b0; end
    check(quiet, "R8 no second cycle after pulse", quiet, 1);
  endtask

  task automatic t_retrigger();
    do_trip(0, 1'b0, 4);
    check(!func_ok, "R10 flag still low before retrigger", func_ok, 0);
    do_trip(1, 1'b0, 5);
    measure_recovery("R10");
  endtask

  task automatic t_bist_held();
    int n, k, exp;
    bist = 1'b1;
    wait_rise(n);
    check(n == 3, "R8 test input raises status", n, 3);
    exp = 5;
    for (int cyc = 0; cyc < 3; cyc++) begin
      k = 0;
      while (ana_en && k < 500) begin tick(); k++; end
      check(k == D || cyc == 0 && k == D, "R8 repeated window length", k, D);
      while (!ana_en && k < 1000) begin tick(); k++; end
      exp = (exp + 1 > 7) ? 7 : exp + 1;
      check(int'(tcount) == exp, "R9 count with saturation", tcount, exp);
      check(!status, "R8 status low at restore", status, 0);
      if (cyc == 2) bist = 1'b0;
      tick();
      check(status, "R8 next window one cycle later", status, 1);
      k = 1;
    end
    k = 0;
    while (status && k < 500) begin
      if (!ana_en) k = 1000;
      tick(); k++;
    end
    check(k < 500 && ana_en, "R8 released test input ends cycling", k, D);
    check(tcount == 7, "R9 saturated count holds", tcount, 7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_transient();
    repeat (5) tick();
    t_trip_dig();
    t_ignore_off();
    repeat (5) tick();
    t_bist_pulse();
    repeat (FL + 5) tick();
    t_retrigger();
    t_bist_held();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule